// File: doc/BRIEF.md
# Pixel Volume Accumulator

This block sits at the end of an image pipeline and totals a frame's worth of signed 9-bit pixels into one "volume" figure. Each valid pixel contributes either its magnitude or the square of its magnitude, depending on a mode bit the host writes. A reserved code stands for negative infinity. That code adds nothing to the total but is still counted as a negative input. A sticky flag records whether any negative pixel reached the block during the frame.

A frame-start strobe clears the running total and the flag. A frame-end strobe copies the total into a result snapshot. The host reads the snapshot one byte at a time through a small register port with an address, a read strobe and a write strobe. The snapshot stays fixed while the next frame accumulates. The running total saturates at its all-ones value and never wraps.

Top module: `pixel_volume_acc`

## Requirements
- R1: After reset, every register address reads 0x00 and the mode is magnitude mode.
- R2: A write to address 0 loads wr_data bit 0 into the mode (0 = magnitude, 1 = square). In magnitude mode a valid pixel p (two's complement, -255..255) adds |p|. Writes to addresses 1 to 7 leave the mode unchanged.
- R3: In square mode a valid pixel adds |p|*|p|, computed from the 8-bit magnitude as a 16-bit product.
- R4: The pixel code 9'h100 (negative infinity) adds nothing to the total.
- R5: Any valid pixel with bit 8 set, including 9'h100, sets the negative flag. The flag then stays set until the next frame start.
- R6: The snapshot is read as follows:
  - address 0 gives result bits 7..0, address 1 bits 15..8, address 2 bits 23..16 and address 3 bits 31..24;
  - address 4 gives the negative flag in bit 7 and result bits 33..32 in bits 1..0, with bits 6..2 zero.
- R7: The running total saturates at 2^SUM_W-1 instead of wrapping. The default SUM_W is 34.
- R8: frame_start clears the total and the flag. A pixel valid in the same cycle is counted as the first pixel of the new frame.
- R9: frame_end copies the total and flag, including any pixel valid in that cycle, into the snapshot. The snapshot changes at no other time.
- R10: rd_en latches the addressed byte onto rd_data at the next clock edge. rd_data holds when rd_en is low, and addresses 5 to 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Clears total and flag for a new frame |
| frame_end | input | 1 | Captures total and flag into the snapshot |
| pix_valid | input | 1 | Qualifies pix_data |
| pix_data | input | 9 | Signed pixel, 9'h100 = negative infinity |
| reg_addr | input | 3 | Host register address |
| rd_en | input | 1 | Host read strobe |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Registered host read data |

## Verification
- The running total takes a pixel on the same edge that samples it. A frame_end in that cycle therefore moves the snapshot on that edge, and the result can be read on the next cycle.
- A read returns data one edge after its strobe. The bench drives inputs on falling edges and samples rd_data on the falling edge after the read strobe's rising edge. This keeps every comparison exactly one register stage behind its stimulus.
- Stability is checked by reading the snapshot while a new frame is still accumulating.
- Saturation is checked with a second instance built with a 20-bit total.
- The upper result bits are checked with a frame long enough to carry past bit 31.

// File: rtl/pva_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the pixel volume accumulator.
package pva_pkg;
    localparam int PIX_W  = 9;
    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;
    localparam int SQ_W   = 16;                        // width of a squared 8-bit magnitude
    localparam int NREG   = 5;                         // readable result bytes
    localparam logic [PIX_W-1:0] PIX_NEG_INF = 9'h100;

    typedef enum logic {
        MODE_MAG = 1'b0,
        MODE_SQR = 1'b1
    } acc_mode_e;
endpackage

// File: rtl/pva_term.sv
`timescale 1ns/1ps
// Converts one pixel into the amount it contributes to the total.
// Assumes pixels are two's complement in -255..255, or the reserved negative-infinity code.
// Purely combinational.
module pva_term
    import pva_pkg::*;
(
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic              mode_sqr,
    output logic [SQ_W-1:0]   term,
    output logic              is_neg
);
    logic [7:0] mag;
    logic       skip;

    // Magnitude, skip decision and mode selection
    always_comb begin
        mag    = pix_data[8] ? 8'(~pix_data[7:0] + 8'd1) : pix_data[7:0];
        skip   = (pix_data == PIX_NEG_INF) || !pix_valid;
        is_neg = pix_valid && pix_data[8];
        if (skip)
            term = '0;
        else if (mode_sqr)
            term = 16'(mag) * 16'(mag);
        else
            term = 16'(mag);
    end
endmodule

// File: rtl/pva_accum.sv
`timescale 1ns/1ps
// Saturating frame accumulator with a sticky negative flag and a frame-end snapshot.
// Assumes SUM_W >= 16. frame_start and frame_end may coincide (a one-pixel frame).
module pva_accum
    import pva_pkg::*;
#(
    parameter int SUM_W = 34
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic [SQ_W-1:0]  term,
    input  logic             is_neg,
    output logic [SUM_W-1:0] acc_q,
    output logic             neg_q,
    output logic [SUM_W-1:0] snap_sum,
    output logic             snap_neg
);
    localparam int PAD_W = SUM_W + 1 - SQ_W;

    logic [SUM_W-1:0] base;
    logic [SUM_W:0]   wide;
    logic [SUM_W-1:0] next_acc;
    logic             next_neg;

    // Next total: clear on frame start, add term, clamp on carry out
    always_comb begin
        base     = frame_start ? '0 : acc_q;
        wide     = {1'b0, base} + {{PAD_W{1'b0}}, term};
        next_acc = wide[SUM_W] ? {SUM_W{1'b1}} : wide[SUM_W-1:0];
        next_neg = (frame_start ? 1'b0 : neg_q) | is_neg;
    end

    // Running state and snapshot registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            neg_q    <= 1'b0;
            snap_sum <= '0;
            snap_neg <= 1'b0;
        end else begin
            acc_q <= next_acc;
            neg_q <= next_neg;
            if (frame_end) begin
                snap_sum <= next_acc;
                snap_neg <= next_neg;
            end
        end
    end
endmodule

// File: rtl/pva_regs.sv
`timescale 1ns/1ps
// Host register file: the mode bit (write at address 0) and the byte-wide read mux.
// Assumes SUM_W <= 39. Read data is registered on the read strobe.
module pva_regs
    import pva_pkg::*;
#(
    parameter int SUM_W = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [SUM_W-1:0]  snap_sum,
    input  logic              snap_neg,
    output logic              mode_sqr,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int EXT_W = BYTE_W * NREG - 1;          // 39 result bits below the flag

    logic [EXT_W-1:0]  ext;
    logic [BYTE_W-1:0] bytes [NREG];
    acc_mode_e         mode_q;

    assign ext = EXT_W'(snap_sum);

    genvar g;
    generate
        for (g = 0; g < NREG - 1; g++) begin : g_low
            assign bytes[g] = ext[g*BYTE_W +: BYTE_W];
        end
    endgenerate
    assign bytes[NREG-1] = {snap_neg, ext[EXT_W-1 -: BYTE_W-1]};

    assign mode_sqr = (mode_q == MODE_SQR);

    // Mode register write and registered read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_MAG;
            rd_data <= '0;
        end else begin
            if (wr_en && reg_addr == '0)
                mode_q <= acc_mode_e'(wr_data[0]);
            if (rd_en)
                rd_data <= (int'(reg_addr) < NREG) ? bytes[reg_addr] : '0;
        end
    end
endmodule

// File: rtl/pixel_volume_acc.sv
`timescale 1ns/1ps
// Pixel volume accumulator top: pixel term, saturating accumulator, host registers.
// Assumes a single clock with a synchronous active-low reset.
module pixel_volume_acc
    import pva_pkg::*;
#(
    parameter int SUM_W = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data
);
    logic [SQ_W-1:0]  term;
    logic             is_neg;
    logic             mode_sqr;
    logic [SUM_W-1:0] acc_q;
    logic             neg_q;
    logic [SUM_W-1:0] snap_sum;
    logic             snap_neg;

    pva_term u_term (
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .mode_sqr  (mode_sqr),
        .term      (term),
        .is_neg    (is_neg)
    );

    pva_accum #(.SUM_W(SUM_W)) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .term        (term),
        .is_neg      (is_neg),
        .acc_q       (acc_q),
        .neg_q       (neg_q),
        .snap_sum    (snap_sum),
        .snap_neg    (snap_neg)
    );

    pva_regs #(.SUM_W(SUM_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .snap_sum (snap_sum),
        .snap_neg (snap_neg),
        .mode_sqr (mode_sqr),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/pva_checker.sv
`timescale 1ns/1ps
// Temporal properties of the pixel volume accumulator, bound into every instance.
module pva_checker
    import pva_pkg::*;
#(
    parameter int SUM_W = 34
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              frame_end,
    input logic              pix_valid,
    input logic [PIX_W-1:0]  pix_data,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [BYTE_W-1:0] rd_data,
    input logic              mode_sqr,
    input logic [SUM_W-1:0]  acc_q,
    input logic              neg_q,
    input logic [SUM_W-1:0]  snap_sum
);
    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr != '0) |=> $stable(mode_sqr));

    assert_neg_inf_adds_nothing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_data == PIX_NEG_INF && !frame_start) |=> (acc_q == $past(acc_q)));

    assert_neg_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_data[8]) |=> neg_q);

    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> (acc_q >= $past(acc_q)));

    assert_frame_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !pix_valid) |=> (acc_q == '0 && !neg_q));

    assert_snap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(snap_sum));

    assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind pixel_volume_acc pva_checker #(.SUM_W(SUM_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .pix_valid   (pix_valid),
    .pix_data    (pix_data),
    .reg_addr    (reg_addr),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .rd_data     (rd_data),
    .mode_sqr    (mode_sqr),
    .acc_q       (acc_q),
    .neg_q       (neg_q),
    .snap_sum    (snap_sum)
);

// File: tb/sim_pixel_volume_acc.sv
`timescale 1ns/1ps
// Bench: u0 uses the default 34-bit total, u1 a 20-bit total for saturation checks.
module sim_pixel_volume_acc;
    localparam int W1 = 20;
    localparam longint MAX0 = (64'd1 << 34) - 1;
    localparam longint MAX1 = (64'd1 << W1) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0, frame_end = 1'b0, pix_valid = 1'b0;
    logic [8:0] pix_data = '0;
    logic [2:0] reg_addr = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd0, rd1;

    int n_tests = 0;
    int n_fail  = 0;

    longint m_acc0 = 0, m_acc1 = 0, s_acc0 = 0, s_acc1 = 0;
    bit     m_neg = 0, s_neg = 0, m_mode = 0;

    always #10 clk = ~clk;

    pixel_volume_acc u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
        .pix_valid(pix_valid), .pix_data(pix_data), .reg_addr(reg_addr),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd0)
    );

    pixel_volume_acc #(.SUM_W(W1)) u1 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
        .pix_valid(pix_valid), .pix_data(pix_data), .reg_addr(reg_addr),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd1)
    );

    function automatic longint term_of(logic [8:0] p, bit sq);
        longint mag;
        if (p == 9'h100) return 0;
        mag = p[8] ? (512 - longint'(p)) : longint'(p);
        return sq ? mag * mag : mag;
    endfunction

    function automatic longint sat_add(longint a, longint t, longint mx);
        return (a + t > mx) ? mx : a + t;
    endfunction

    function automatic logic [7:0] exp_byte(longint s, bit neg, int a);
        if (a < 4) return 8'((s >> (8 * a)) & 64'hFF);
        if (a == 4) return {neg, 7'((s >> 32) & 64'h7F)};
        return 8'h00;
    endfunction

    task automatic chk(bit ok, string req, longint got, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // One pixel-side cycle, mirrored in the model
    task automatic cyc(bit v, logic [8:0] p, bit fs, bit fe);
        @(negedge clk);
        pix_valid = v; pix_data = p; frame_start = fs; frame_end = fe;
        if (fs) begin m_acc0 = 0; m_acc1 = 0; m_neg = 0; end
        if (v) begin
            m_acc0 = sat_add(m_acc0, term_of(p, m_mode), MAX0);
            m_acc1 = sat_add(m_acc1, term_of(p, m_mode), MAX1);
            if (p[8]) m_neg = 1;
        end
        if (fe) begin s_acc0 = m_acc0; s_acc1 = m_acc1; s_neg = m_neg; end
    endtask

    task automatic idle();
        cyc(0, 9'h000, 0, 0);
    endtask

    task automatic host_wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        pix_valid = 0; frame_start = 0; frame_end = 0;
        reg_addr = a; wr_data = d; wr_en = 1;
        if (a == 0) m_mode = d[0];
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic host_rd(logic [2:0] a, output logic [7:0] b0, output logic [7:0] b1);
        @(negedge clk);
        pix_valid = 0; frame_start = 0; frame_end = 0;
        reg_addr = a; rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        b0 = rd0; b1 = rd1;
    endtask

    task automatic check_regs(string req);
        logic [7:0] b0, b1;
        for (int a = 0; a < 5; a++) begin
            host_rd(3'(a), b0, b1);
            chk(b0 == exp_byte(s_acc0, s_neg, a), req, b0, exp_byte(s_acc0, s_neg, a));
            chk(b1 == exp_byte(s_acc1, s_neg, a), req, b1, exp_byte(s_acc1, s_neg, a));
        end
    endtask

    // Watchdog
    initial begin
        #3000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: got 0x0 expected 0x1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] b0, b1;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state of all registers
        check_regs("R1");

        // R2 R4 R5 R6: magnitude frame with negatives and negative infinity
        cyc(1, 9'd5, 1, 0); cyc(1, 9'h1FD, 0, 0); cyc(1, 9'd255, 0, 0);
        cyc(1, 9'h101, 0, 0); cyc(1, 9'h100, 0, 1); idle();
        check_regs("R2_R4_R5_R6");

        // R3 R7: square mode, u1 saturates at 2^20-1
        host_wr(3'd0, 8'h01);
        cyc(1, 9'd255, 1, 0);
        for (int i = 0; i < 18; i++) cyc(1, 9'd255, 0, 0);
        cyc(1, 9'd255, 0, 1); idle();
        check_regs("R3_R7");

        // R2: writes to other addresses leave square mode in place
        host_wr(3'd3, 8'h00); host_wr(3'd1, 8'hFE);
        cyc(1, 9'd3, 1, 1); idle();
        check_regs("R2_ignore");

        // R9: reads stay fixed while a new frame accumulates
        cyc(1, 9'd7, 1, 0); cyc(1, 9'h1F0, 0, 0);
        check_regs("R9_stable");
        cyc(1, 9'd2, 0, 1); idle();
        check_regs("R9_capture");

        // R8: frame_start clears, same-cycle pixel counts
        host_wr(3'd0, 8'h00);
        cyc(1, 9'd9, 1, 0); cyc(1, 9'd1, 1, 1); idle();
        check_regs("R8");

        // R10: unused addresses read zero; rd_data holds without strobe
        for (int a = 5; a < 8; a++) begin
            host_rd(3'(a), b0, b1);
            chk(b0 == 8'h00 && b1 == 8'h00, "R10_unused", b0, 0);
        end
        host_rd(3'd0, b0, b1);
        @(negedge clk); reg_addr = 3'd4;
        @(negedge clk);
        chk(rd0 == b0, "R10_hold", rd0, b0);

        // Random frames
        for (int f = 0; f < 30; f++) begin
            int len;
            host_wr(3'd0, 8'($urandom_range(0, 1)));
            len = $urandom_range(1, 60);
            for (int i = 0; i < len; i++) begin
                logic [8:0] p;
                bit v;
                p = ($urandom_range(0, 7) == 0) ? 9'h100 : 9'($signed($urandom_range(0, 510)) - 255);
                v = (i == 0 || i == len - 1) ? 1'b1 : 1'($urandom_range(0, 3) != 0);
                cyc(v, p, i == 0, i == len - 1);
            end
            idle();
            check_regs("R2_R3_R5_R6_random");
        end

        // R6: long square frame carries past bit 31 in u0
        host_wr(3'd0, 8'h01);
        cyc(1, 9'd255, 1, 0);
        for (int i = 0; i < 66098; i++) cyc(1, 9'h101, 0, 0);
        cyc(1, 9'd255, 0, 1); idle();
        check_regs("R6_high");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule